// File: doc/BRIEF.md
# Byte-to-Word Packing FIFO

A single-clock FIFO that takes byte-wide writes and hands out words four bytes wide. Each run of four accepted writes is gathered into one wide entry. Only complete groups are stored and become visible to the reader. A build parameter decides which lane of the wide word receives the first byte of a group. The choice is either the most significant lane or the least significant lane.

Capacity and threshold figures are given in bytes. The read side is first-word-fall-through: whenever the FIFO is not empty, the oldest complete word is already on the output with no read latency, and asserting the read request retires it. Writes that arrive while full and reads that arrive while empty are refused without harming the stored data, and each refusal is reported by a one-cycle pulse.

Top module: `byte_pack_fifo`

## Requirements
- R1: With MSB_FIRST=1, a group of bytes written b0,b1,b2,b3 is read as {b0,b1,b2,b3}: b0 in dout[31:24] and b3 in dout[7:0].
- R2: With MSB_FIRST=0, the same group is read as {b3,b2,b1,b0}: b0 in dout[7:0] and b3 in dout[31:24].
- R3: Fall-through output. After the clock edge that accepts the fourth byte of a group into an empty FIFO, empty is low and dout already holds that word. A read with empty low retires the head word at the next edge.
- R4: After one, two or three bytes of a new group have been accepted, empty stays high and dout stays zero.
- R5: full is high when the stored byte count equals DEPTH. A write while full is dropped and leaves the contents unchanged. overflow is high for exactly the one cycle after that edge.
- R6: A read while empty changes nothing. underflow is high for exactly the one cycle after that edge.
- R7: almost_full is high when the byte count equals DEPTH-1. almost_empty is high when exactly one complete word is stored.
- R8: prog_full is high when the byte count is at least PROG_TH, and low when it is below PROG_TH.
- R9: wr_ack is high for the cycle after each accepted write, and low after a refused write.
- R10: While rst_n is low, and right after it is released: empty=1, dout=0, and full, almost_full, prog_full, almost_empty, overflow, underflow and wr_ack are all 0. Any partial group is discarded.
- R11: If the edge that completes a group also retires the head word, the stored word count is unchanged and the new word becomes the head in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write request |
| din | input | IN_W | Write byte |
| full | output | 1 | No byte can be accepted |
| almost_full | output | 1 | Exactly one more byte fits |
| prog_full | output | 1 | Byte count at or above PROG_TH |
| overflow | output | 1 | Previous write was refused |
| wr_ack | output | 1 | Previous write was accepted |
| rd_en | input | 1 | Retire the head word |
| dout | output | IN_W*RATIO | Head word, zero while empty |
| empty | output | 1 | No complete word stored |
| almost_empty | output | 1 | Exactly one complete word stored |
| underflow | output | 1 | Previous read was refused |

## Verification
The hardest case to reach from the ports is the edge where a group is completed and the head word is retired in the same cycle. It needs a stored word, three bytes of a pending group, and then a read and the final byte issued together. The bench builds that state byte by byte before firing both requests at once. It then confirms that empty stays low, that almost_empty stays high, and that dout moves to the new word.

The overflow case also takes deliberate setup. The bench fills the FIFO to the exact byte capacity, then pushes one extra byte. It then drains the FIFO, and the drained words show whether the extra byte leaked into the stored data.

// File: rtl/byte_pack_pkg.sv
`timescale 1ns/1ps
package byte_pack_pkg;
  // Map a byte position within a group to its output lane (self-inverse).
  function automatic int unsigned lane_of(input int unsigned slot,
                                          input int unsigned ratio,
                                          input bit          msb_first);
    return msb_first ? (ratio - 1 - slot) : slot;
  endfunction
endpackage

// File: rtl/byte_packer.sv
`timescale 1ns/1ps
module byte_packer #(
  parameter int IN_W      = 8,
  parameter int RATIO     = 4,
  parameter bit MSB_FIRST = 1'b1,
  localparam int OUT_W    = IN_W * RATIO,
  localparam int SW       = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [IN_W-1:0]  din,
  output logic             commit,
  output logic [OUT_W-1:0] word,
  output logic [SW-1:0]    slot
);
  logic [SW-1:0]    slot_q, slot_d;
  logic [OUT_W-1:0] acc_q, acc_d;
  logic             last;

  assign last = (slot_q == SW'(RATIO - 1));

  for (genvar g = 0; g < RATIO; g++) begin : g_lane
    localparam int unsigned SLOT_G = byte_pack_pkg::lane_of(g, RATIO, MSB_FIRST);
    assign word[g*IN_W +: IN_W] = (slot_q == SW'(SLOT_G)) ? din : acc_q[g*IN_W +: IN_W];
  end

  always_comb begin
    slot_d = slot_q;
    acc_d  = acc_q;
    if (accept) begin
      slot_d = last ? '0 : slot_q + SW'(1);
      acc_d  = last ? '0 : word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      acc_q  <= '0;
    end else begin
      slot_q <= slot_d;
      acc_q  <= acc_d;
    end
  end

  assign commit = accept && last;
  assign slot   = slot_q;
endmodule

// File: rtl/word_store.sv
`timescale 1ns/1ps
module word_store #(
  parameter int W      = 32,
  parameter int WORDS  = 256,
  localparam int PW    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int LW    = $clog2(WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [WORDS];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] level_q, level_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (push) wr_ptr_d = (wr_ptr_q == PW'(WORDS - 1)) ? '0 : wr_ptr_q + PW'(1);
    if (pop)  rd_ptr_d = (rd_ptr_q == PW'(WORDS - 1)) ? '0 : rd_ptr_q + PW'(1);
    if (push && !pop) level_d = level_q + LW'(1);
    else if (pop && !push) level_d = level_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wdata;
  end

  assign head  = mem[rd_ptr_q];
  assign level = level_q;
endmodule

// File: rtl/fifo_flags.sv
`timescale 1ns/1ps
module fifo_flags #(
  parameter int DEPTH   = 1024,
  parameter int RATIO   = 4,
  parameter int PROG_TH = 500,
  parameter int LW      = 9,
  parameter int SW      = 2,
  localparam int BW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] level,
  input  logic [SW-1:0] slot,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic          full,
  output logic          almost_full,
  output logic          prog_full,
  output logic          empty,
  output logic          almost_empty,
  output logic          overflow,
  output logic          wr_ack,
  output logic          underflow
);
  logic [BW-1:0] byte_cnt;
  logic ovf_q, ovf_d, ack_q, ack_d, udf_q, udf_d;

  assign byte_cnt     = BW'(level) * BW'(RATIO) + BW'(slot);
  assign full         = (byte_cnt == BW'(DEPTH));
  assign almost_full  = (byte_cnt == BW'(DEPTH - 1));
  assign prog_full    = (byte_cnt >= BW'(PROG_TH));
  assign empty        = (level == '0);
  assign almost_empty = (level == LW'(1));
  assign wr_ok        = wr_en && !full;
  assign rd_ok        = rd_en && !empty;

  always_comb begin
    ovf_d = wr_en && full;
    ack_d = wr_ok;
    udf_d = rd_en && empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      ack_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      ack_q <= ack_d;
      udf_q <= udf_d;
    end
  end

  assign overflow  = ovf_q;
  assign wr_ack    = ack_q;
  assign underflow = udf_q;
endmodule

// File: rtl/byte_pack_fifo.sv
`timescale 1ns/1ps
module byte_pack_fifo #(
  parameter int IN_W      = 8,
  parameter int RATIO     = 4,
  parameter int DEPTH     = 1024,
  parameter int PROG_TH   = 500,
  parameter bit MSB_FIRST = 1'b1,
  localparam int OUT_W    = IN_W * RATIO,
  localparam int WORDS    = DEPTH / RATIO,
  localparam int LW       = $clog2(WORDS + 1),
  localparam int SW       = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IN_W-1:0]  din,
  output logic             full,
  output logic             almost_full,
  output logic             prog_full,
  output logic             overflow,
  output logic             wr_ack,
  input  logic             rd_en,
  output logic [OUT_W-1:0] dout,
  output logic             empty,
  output logic             almost_empty,
  output logic             underflow
);
  logic             wr_ok, rd_ok, commit;
  logic [OUT_W-1:0] packed_word, head;
  logic [SW-1:0]    slot;
  logic [LW-1:0]    level;

  byte_packer #(.IN_W(IN_W), .RATIO(RATIO), .MSB_FIRST(MSB_FIRST)) u_pack (
    .clk(clk), .rst_n(rst_n), .accept(wr_ok), .din(din),
    .commit(commit), .word(packed_word), .slot(slot));

  word_store #(.W(OUT_W), .WORDS(WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .push(commit), .pop(rd_ok),
    .wdata(packed_word), .head(head), .level(level));

  fifo_flags #(.DEPTH(DEPTH), .RATIO(RATIO), .PROG_TH(PROG_TH), .LW(LW), .SW(SW)) u_flags (
    .clk(clk), .rst_n(rst_n), .level(level), .slot(slot),
    .wr_en(wr_en), .rd_en(rd_en), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .full(full), .almost_full(almost_full), .prog_full(prog_full),
    .empty(empty), .almost_empty(almost_empty), .overflow(overflow),
    .wr_ack(wr_ack), .underflow(underflow));

  assign dout = empty ? '0 : head;
endmodule

// File: rtl/byte_pack_fifo_chk.sv
`timescale 1ns/1ps
module byte_pack_fifo_chk #(
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic             full,
  input logic             almost_full,
  input logic             prog_full,
  input logic             overflow,
  input logic             wr_ack,
  input logic             empty,
  input logic             almost_empty,
  input logic             underflow,
  input logic [OUT_W-1:0] dout
);
  a_r5_overflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> (overflow && !wr_ack));
  a_r5_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> full);
  a_r6_underflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> underflow);
  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full) |=> (wr_ack && !overflow));
  a_r3_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !rd_en) |=> (!empty && $stable(dout)));
  a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (dout == '0));
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full, almost_full}) && $onehot0({empty, almost_empty}));
  a_r8_full_implies_prog: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> prog_full);
endmodule

bind byte_pack_fifo byte_pack_fifo_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .full(full),
  .almost_full(almost_full), .prog_full(prog_full), .overflow(overflow),
  .wr_ack(wr_ack), .empty(empty), .almost_empty(almost_empty),
  .underflow(underflow), .dout(dout));

// File: tb/sim_byte_pack_fifo.sv
`timescale 1ns/1ps
module sim_byte_pack_fifo;
  localparam int DEPTH = 16;
  localparam int PTH   = 10;
  localparam int NV    = 6;
  // Each entry lists a group in write order: first byte in [31:24].
  localparam logic [31:0] VEC [NV] = '{32'h11223344, 32'hA0B1C2D3, 32'h00FF00FF,
                                       32'h80000001, 32'hDEADBEEF, 32'h0F1E2D3C};

  logic clk, rst_n, wr_en, rd_en;
  logic [7:0]  din;
  logic [31:0] dout0, dout1;
  logic full, afull, pfull, ovf, ack, empty, aempty, udf;
  logic full1, afull1, pfull1, ovf1, ack1, empty1, aempty1, udf1;
  int errors = 0, checks = 0;
  bit done = 0;

  byte_pack_fifo #(.DEPTH(DEPTH), .PROG_TH(PTH), .MSB_FIRST(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .full(full),
    .almost_full(afull), .prog_full(pfull), .overflow(ovf), .wr_ack(ack),
    .rd_en(rd_en), .dout(dout0), .empty(empty), .almost_empty(aempty), .underflow(udf));

  byte_pack_fifo #(.DEPTH(DEPTH), .PROG_TH(PTH), .MSB_FIRST(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .full(full1),
    .almost_full(afull1), .prog_full(pfull1), .overflow(ovf1), .wr_ack(ack1),
    .rd_en(rd_en), .dout(dout1), .empty(empty1), .almost_empty(aempty1), .underflow(udf1));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] swap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [7:0] b, input logic rd);
    wr_en = 1'b1; din = b; rd_en = rd;
    tick();
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic put_word(input logic [31:0] v);
    for (int k = 3; k >= 0; k--) put(v[k*8 +: 8], 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; din = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 flags in reset", {empty, full, afull, pfull, aempty, ovf, udf, ack},
        {1'b1, 7'b0});
    chk("R10 dout in reset", dout0, 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R10 flags after release", {empty, full, afull, pfull, aempty, ovf, udf, ack},
        {1'b1, 7'b0});

    // Table walk: R1, R2, R3, R4, R7, R9
    for (int i = 0; i < NV; i++) begin
      for (int k = 3; k >= 1; k--) put(VEC[i][k*8 +: 8], 1'b0);
      chk("R4 partial group hidden", {empty, empty1, 1'b0}, 3'b110);
      chk("R4 dout zero on partial", dout0, 32'h0);
      put(VEC[i][7:0], 1'b0);
      chk("R9 ack after accepted write", {31'b0, ack}, 32'h1);
      chk("R3 word falls through", {31'b0, empty}, 32'h0);
      chk("R1 msb-first packing", dout0, VEC[i]);
      chk("R2 lsb-first packing", dout1, swap(VEC[i]));
      chk("R7 almost_empty one word", {31'b0, aempty}, 32'h1);
      pop();
      chk("R3 read retires head", {31'b0, empty}, 32'h1);
    end

    // R6: read while empty
    pop();
    chk("R6 underflow pulse", {31'b0, udf}, 32'h1);
    tick();
    chk("R6 underflow one cycle", {30'b0, udf, empty}, 32'h1);

    // Fill to capacity: R5, R7, R8
    for (int k = 0; k < DEPTH; k++) begin
      put(8'h40 + 8'(k), 1'b0);
      if (k == PTH - 2) chk("R8 below threshold", {31'b0, pfull}, 32'h0);
      if (k == PTH - 1) chk("R8 at threshold", {31'b0, pfull}, 32'h1);
      if (k == DEPTH - 2) chk("R7 almost_full", {30'b0, afull, full}, 32'h2);
    end
    chk("R5 full at capacity", {30'b0, afull, full}, 32'h1);
    put(8'hEE, 1'b0);
    chk("R5 overflow pulse", {30'b0, ovf, ack}, 32'h2);
    chk("R9 no ack on refused write", {31'b0, ack}, 32'h0);
    tick();
    chk("R5 overflow one cycle", {31'b0, ovf}, 32'h0);
    for (int j = 0; j < DEPTH / 4; j++) begin
      logic [31:0] e;
      e = {8'h40 + 8'(4*j), 8'h41 + 8'(4*j), 8'h42 + 8'(4*j), 8'h43 + 8'(4*j)};
      chk("R5 contents intact msb", dout0, e);
      chk("R5 contents intact lsb", dout1, swap(e));
      pop();
    end
    chk("R5 drained", {30'b0, empty, full}, 32'h2);

    // R11: group completes on the same edge that retires the head
    put_word(32'hCAFE0001);
    put(8'h12, 1'b0); put(8'h34, 1'b0); put(8'h56, 1'b0);
    chk("R11 head before overlap", dout0, 32'hCAFE0001);
    put(8'h78, 1'b1);
    chk("R11 count kept", {30'b0, empty, aempty}, 32'h1);
    chk("R11 new head msb", dout0, 32'h12345678);
    chk("R11 new head lsb", dout1, 32'h78563412);
    pop();

    // R10: reset mid-operation drops partial and stored data
    put_word(32'h01020304);
    put(8'h99, 1'b0);
    rst_n = 1'b0;
    #2;
    chk("R10 async reset clears", {empty, aempty, ack, dout0[0]}, 4'b1000);
    chk("R10 dout zero", dout0, 32'h0);
    tick();
    rst_n = 1'b1;
    put_word(32'hA1B2C3D4);
    chk("R10 partial discarded", dout0, 32'hA1B2C3D4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule